// File: doc/BRIEF.md
# Redundant Configuration Shadow Loader

After every reset this block copies a fixed number of configuration words from nonvolatile storage into volatile shadow registers. It issues word reads one at a time to a memory read port. The port answers after a variable number of cycles, and each answer carries data plus two ECC flags: one for a single-bit error, which the port has already corrected, and one for a double-bit error, which it cannot correct. The load starts at the primary copy. If any word of that copy comes back with an uncorrectable error, the loader drops the pass and starts again at word 0 of the duplicate copy. If the duplicate copy also fails, the loader stops and reports a fatal failure.

Each shadow bit is stored twice, once true and once inverted. When the load has finished, the shadow contents are frozen. From then on every pair is compared on every cycle, and any pair that is no longer complementary raises a sticky integrity flag. Until the load completes, the shadow outputs stay at zero. A fault-injection port can flip stored complement bits, so that a storage upset can be modelled.

The sequencer has six states:
- `S_START`: the first cycle after reset.
- `S_REQ`: issues one read.
- `S_WAIT`: waits for the answer.
- `S_SWITCH`: moves the pass to the duplicate copy.
- `S_DONE`: load complete.
- `S_FAIL`: fatal.

Its transitions are:
- START→REQ always.
- REQ→WAIT always.
- WAIT→REQ on a clean or corrected word that is not the last.
- WAIT→DONE on a clean or corrected last word.
- WAIT→SWITCH on a double-bit error in the primary copy.
- WAIT→FAIL on a double-bit error in the duplicate copy.
- SWITCH→REQ always.
- DONE and FAIL hold until reset.

Top module: `cfg_shadow_loader`

## Requirements
- R1: Every reset starts a new load from word 0 of the primary copy, whatever state the previous load ended in.
- R2: At most one read is outstanding at a time. Within one copy the read address starts at that copy's base (primary 0x7F3000, duplicate 0x7FB000) and grows by 4 per word, for NUM_WORDS words.
- R3: A double-bit error flag on any word of the primary copy makes the next read go to the duplicate base at word 0. It also sets `fallback_used`, which stays set until reset.
- R4: A word returned with only the single-bit flag is stored, causes no fallback, and increments `corr_count` (saturating, cleared by reset).
- R5: A double-bit error in the duplicate copy sets `load_fail`, keeps `load_done` low and issues no further reads.
- R6: `shadow_cfg` is all zeros until `load_done`. After that, bits [i*WORD_W +: WORD_W] hold word i of the copy that completed.
- R7: After `load_done`, any true/complement pair that stops being complementary sets `integrity_err`, which stays set until reset. Upsets before `load_done` are repaired by the load and do not set it.
- R8: After `load_done`, read responses arriving on the port do not change the shadow contents.
- R9: Reset clears `fallback_used`, `load_fail`, `load_done`, `integrity_err` and `corr_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; each release starts a load |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read answer present this cycle |
| rd_data | input | WORD_W | Read data (already corrected when single-bit flag set) |
| rd_sbe | input | 1 | Corrected single-bit error flag |
| rd_dbe | input | 1 | Uncorrectable double-bit error flag |
| upset_en | input | 1 | Fault injection: flip complement bits this cycle |
| upset_idx | input | IDX_W | Fault injection: target word |
| upset_mask | input | WORD_W | Fault injection: bits to flip |
| shadow_cfg | output | NUM_WORDS*WORD_W | Shadow configuration values |
| load_done | output | 1 | Load completed |
| fallback_used | output | 1 | Duplicate copy was used (sticky) |
| load_fail | output | 1 | Both copies failed |
| integrity_err | output | 1 | A true/complement pair mismatched (sticky) |
| corr_count | output | CNT_W | Corrected-error count |

## Verification
The bench drives a double-bit error at the first, a middle and the last word of the primary copy. A loader that resumed at the failing index, or that kept a word of the primary copy in the shadow, would read the wrong number of words or end with mixed data. It pairs a primary failure with a corrected error, and with a second failure, in the duplicate copy. This exposes a counter that misses corrections, a loader that switches a second time instead of stopping, and a design that still requests reads after it has failed. It flips complement bits both before and after completion, and sends a stray read answer after completion. This catches a checker that runs during the load, a flag that is not sticky, and shadow storage that stays writable.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
    typedef enum logic [2:0] {
        S_START,
        S_REQ,
        S_WAIT,
        S_SWITCH,
        S_DONE,
        S_FAIL
    } ldr_state_t;
endpackage

// File: rtl/cfg_ldr_fsm.sv
module cfg_ldr_fsm
    import cfg_ldr_pkg::*;
#(
    parameter int                NUM_WORDS = 8,
    parameter int                ADDR_W    = 24,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] PRI_BASE  = 24'h7F3000,
    parameter logic [ADDR_W-1:0] ALT_BASE  = 24'h7FB000,
    localparam int               IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_sbe,
    input  logic              rd_dbe,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              done,
    output logic              fail,
    output logic              fallback,
    output logic [CNT_W-1:0]  corr_cnt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    ldr_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             alt_q;
    logic             resp_ok;
    logic             is_last;

    assign resp_ok = (state_q == S_WAIT) && rd_valid && !rd_dbe;
    assign is_last = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_START;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_START:  state_d = S_REQ;
            S_REQ:    state_d = S_WAIT;
            S_WAIT: begin
                if (rd_valid) begin
                    if (rd_dbe)       state_d = alt_q ? S_FAIL : S_SWITCH;
                    else if (is_last) state_d = S_DONE;
                    else              state_d = S_REQ;
                end
            end
            S_SWITCH: state_d = S_REQ;
            S_DONE:   state_d = S_DONE;
            S_FAIL:   state_d = S_FAIL;
            default:  state_d = S_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            alt_q    <= 1'b0;
            fallback <= 1'b0;
            corr_cnt <= '0;
        end else begin
            if (resp_ok && !is_last) idx_q <= idx_q + 1'b1;
            if (state_q == S_SWITCH) begin
                idx_q    <= '0;
                alt_q    <= 1'b1;
                fallback <= 1'b1;
            end
            if (resp_ok && rd_sbe && corr_cnt != CNT_MAX) corr_cnt <= corr_cnt + 1'b1;
        end
    end

    always_comb begin
        rd_req  = (state_q == S_REQ);
        rd_addr = (alt_q ? ALT_BASE : PRI_BASE) + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
        wr_en   = resp_ok;
        wr_idx  = idx_q;
        done    = (state_q == S_DONE);
        fail    = (state_q == S_FAIL);
    end

    // R2: a request is never followed directly by another
    a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R5: once failed, no reads
    a_r5_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !rd_req && !done);
    // R3: fallback flag sticky
    a_r3_fallback_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fallback |=> fallback);
    // R4: corrected count never decreases
    a_r4_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> corr_cnt >= $past(corr_cnt));
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
    parameter int  NUM_WORDS = 8,
    parameter int  WORD_W    = 32,
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int FLAT_W    = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lock,
    input  logic              upset_en,
    input  logic [IDX_W-1:0]  upset_idx,
    input  logic [WORD_W-1:0] upset_mask,
    output logic [FLAT_W-1:0] shadow_out,
    output logic              integrity_err
);
    logic [NUM_WORDS-1:0] pair_bad;
    logic [FLAT_W-1:0]    true_flat;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] true_q, comp_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                true_q <= '0;
                comp_q <= '1;
            end else if (wr_en && !lock && wr_idx == IDX_W'(w)) begin
                true_q <= wr_data;
                comp_q <= ~wr_data;
            end else if (upset_en && upset_idx == IDX_W'(w)) begin
                comp_q <= comp_q ^ upset_mask;
            end
        end

        assign pair_bad[w]                  = |(true_q ~^ comp_q);
        assign true_flat[w*WORD_W +: WORD_W] = true_q;
        assign shadow_out[w*WORD_W +: WORD_W] = lock ? true_q : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 integrity_err <= 1'b0;
        else if (lock && |pair_bad) integrity_err <= 1'b1;
    end

    // R8: stored true bits frozen once locked
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(true_flat));
    // R7: integrity flag sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        integrity_err |=> integrity_err);
endmodule

// File: rtl/cfg_shadow_loader.sv
module cfg_shadow_loader #(
    parameter int                NUM_WORDS = 8,
    parameter int                WORD_W    = 32,
    parameter int                ADDR_W    = 24,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] PRI_BASE  = 24'h7F3000,
    parameter logic [ADDR_W-1:0] ALT_BASE  = 24'h7FB000,
    localparam int               IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        rd_req,
    output logic [ADDR_W-1:0]           rd_addr,
    input  logic                        rd_valid,
    input  logic [WORD_W-1:0]           rd_data,
    input  logic                        rd_sbe,
    input  logic                        rd_dbe,
    input  logic                        upset_en,
    input  logic [IDX_W-1:0]            upset_idx,
    input  logic [WORD_W-1:0]           upset_mask,
    output logic [NUM_WORDS*WORD_W-1:0] shadow_cfg,
    output logic                        load_done,
    output logic                        fallback_used,
    output logic                        load_fail,
    output logic                        integrity_err,
    output logic [CNT_W-1:0]            corr_count
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    cfg_ldr_fsm #(
        .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_idx(wr_idx),
        .done(load_done), .fail(load_fail),
        .fallback(fallback_used), .corr_cnt(corr_count)
    );

    cfg_shadow_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rd_data),
        .lock(load_done),
        .upset_en(upset_en), .upset_idx(upset_idx), .upset_mask(upset_mask),
        .shadow_out(shadow_cfg), .integrity_err(integrity_err)
    );

    // R6: safe default while not loaded
    a_r6_safe_default: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> shadow_cfg == '0);
    // R5: done and fail never together
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_fail));
endmodule

// File: tb/sim_cfg_shadow_loader.sv
module sim_cfg_shadow_loader;
    localparam int CLK_P = 10;
    localparam int NW    = 8;
    localparam int WW    = 32;
    localparam logic [23:0] PRI = 24'h7F3000;
    localparam logic [23:0] ALT = 24'h7FB000;

    typedef struct packed {
        logic [3:0] pw; logic [1:0] pk;   // primary error word / kind (0 none,1 sbe,2 dbe)
        logic [3:0] aw; logic [1:0] ak;   // duplicate error word / kind
        logic [1:0] lat;
        logic ed, ef, el;                 // expected done, fallback, fail
        logic [3:0] ec;                   // expected corrected count
        logic [5:0] er;                   // expected read count
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd0, 2'd0, 4'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 6'd8},
        '{4'd3, 2'd1, 4'd0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 4'd1, 6'd8},
        '{4'd5, 2'd2, 4'd0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0, 6'd14},
        '{4'd0, 2'd2, 4'd7, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 4'd1, 6'd9},
        '{4'd2, 2'd2, 4'd4, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 4'd0, 6'd8},
        '{4'd7, 2'd2, 4'd0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 4'd0, 6'd16}
    };

    logic clk = 0, rst_n = 0;
    logic rd_req, rd_valid = 0, rd_sbe = 0, rd_dbe = 0;
    logic [23:0] rd_addr;
    logic [WW-1:0] rd_data = '0;
    logic upset_en = 0;
    logic [2:0] upset_idx = '0;
    logic [WW-1:0] upset_mask = '0;
    logic [NW*WW-1:0] shadow_cfg;
    logic load_done, fallback_used, load_fail, integrity_err;
    logic [7:0] corr_count;

    int total = 0, bad = 0;
    vec_t cur;
    int reads, addr_bad;
    logic [23:0] exp_addr;
    bit force_valid = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_shadow_loader u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
        .upset_en(upset_en), .upset_idx(upset_idx), .upset_mask(upset_mask),
        .shadow_cfg(shadow_cfg), .load_done(load_done), .fallback_used(fallback_used),
        .load_fail(load_fail), .integrity_err(integrity_err), .corr_count(corr_count)
    );

    function automatic logic [31:0] word_of(input bit alt, input int i);
        return alt ? (32'h5A00_0007 + 32'(i) * 32'h0001_0203)
                   : (32'hC3F0_0000 ^ (32'(i) * 32'h1111_1111));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // memory model, acts at negedge
    initial begin
        bit busy = 0; int cnt = 0; bit cp = 0; int ix = 0;
        forever begin
            @(negedge clk);
            rd_valid = 0; rd_sbe = 0; rd_dbe = 0;
            if (!rst_n) begin
                busy = 0; reads = 0; addr_bad = 0; exp_addr = PRI;
            end else begin
                if (busy) begin
                    cnt--;
                    if (cnt == 0) begin
                        logic [1:0] k;
                        busy = 0;
                        k = (!cp && ix == int'(cur.pw)) ? cur.pk :
                            ( cp && ix == int'(cur.aw)) ? cur.ak : 2'd0;
                        rd_valid = 1; rd_data = word_of(cp, ix);
                        rd_sbe = (k == 2'd1); rd_dbe = (k == 2'd2);
                        if (k == 2'd2 && !cp) exp_addr = ALT;
                    end
                end
                if (force_valid) begin
                    rd_valid = 1; rd_data = 32'hDEAD_BEEF;
                end
                if (rd_req) begin
                    reads++;
                    if (busy) addr_bad++;
                    if (rd_addr != exp_addr) addr_bad++;
                    exp_addr = exp_addr + 24'd4;
                    cp = (rd_addr >= ALT);
                    ix = int'((rd_addr - (cp ? ALT : PRI)) >> 2);
                    busy = 1; cnt = int'(cur.lat);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_end();
        for (int t = 0; t < 2000 && !load_done && !load_fail; t++) @(negedge clk);
    endtask

    task automatic check_shadow(input string req, input bit alt);
        logic [NW*WW-1:0] e;
        for (int i = 0; i < NW; i++) e[i*WW +: WW] = word_of(alt, i);
        total++;
        if (shadow_cfg !== e) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, shadow_cfg, e);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur = VEC[0];
        // reset state, R9 and R6
        repeat (2) @(negedge clk);
        check("R9 done at reset", 64'(load_done), 64'd0);
        check("R9 fail at reset", 64'(load_fail), 64'd0);
        check("R6 shadow at reset", 64'(shadow_cfg == '0), 64'd1);

        for (int v = 0; v < 6; v++) begin
            cur = VEC[v];
            do_reset();                    // R1: every reset starts a fresh load
            check("R9 fallback cleared", 64'(fallback_used), 64'd0);
            check("R9 count cleared", 64'(corr_count), 64'd0);
            wait_end();
            repeat (10) @(negedge clk);
            check("R6 done flag", 64'(load_done), 64'(cur.ed));
            check("R3 fallback flag", 64'(fallback_used), 64'(cur.ef));
            check("R5 fail flag", 64'(load_fail), 64'(cur.el));
            check("R4 corrected count", 64'(corr_count), 64'(cur.ec));
            check("R1 R5 read count", 64'(reads), 64'(cur.er));
            check("R2 address order", 64'(addr_bad), 64'd0);
            if (cur.ed) check_shadow("R6 shadow content", cur.ef);
            else check("R5 shadow zero on fail", 64'(shadow_cfg == '0), 64'd1);
        end

        // R6 mid-load default and R7 upset before done
        cur = VEC[3];
        do_reset();
        upset_en = 1; upset_idx = 3'd0; upset_mask = 32'h0000_0100;
        @(negedge clk); upset_en = 0;
        repeat (8) @(negedge clk);
        check("R6 busy not done", 64'(load_done), 64'd0);
        check("R6 zero while loading", 64'(shadow_cfg == '0), 64'd1);
        wait_end();
        repeat (3) @(negedge clk);
        check("R7 pre-done upset ignored", 64'(integrity_err), 64'd0);

        // R8 stray answer after done
        force_valid = 1; @(negedge clk); force_valid = 0;
        repeat (3) @(negedge clk);
        check_shadow("R8 shadow frozen", 1'b1);
        check("R8 no extra reads", 64'(reads), 64'd9);

        // R7 upset after done
        upset_en = 1; upset_idx = 3'd5; upset_mask = 32'h8000_0000;
        @(negedge clk); upset_en = 0;
        repeat (3) @(negedge clk);
        check("R7 integrity raised", 64'(integrity_err), 64'd1);
        check_shadow("R7 true bits intact", 1'b1);
        repeat (5) @(negedge clk);
        check("R7 integrity sticky", 64'(integrity_err), 64'd1);
        do_reset();
        check("R9 integrity cleared", 64'(integrity_err), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule